// File: doc/BRIEF.md
# Multicycle 16-bit Block-Copy Processor

This block is a small 16-bit processor that steps through every instruction as a fixed sequence of states. It has eight general registers, a program counter, an instruction register and a registered memory address. It talks to a single word-addressed memory over a 16-bit address, a write-data bus, a read-data bus, an access-valid strobe and a direction strobe. Its six instructions (register load and store through a pointer, load of an immediate, unconditional jump, compare-and-jump on unsigned greater-than, and register increment) are enough to run a loop that copies a block of memory words from one region to another.

Each instruction starts with a two-cycle fetch. In the first cycle the program counter is copied into the address register. In the second cycle the memory word is read into the instruction register and the program counter is stepped through the shared incrementer. A decode cycle follows. Instructions that carry an immediate or a jump target read a second word at the program counter. One incrementer serves both the program counter and the increment instruction.

Top module: `cpu16_blkcopy`

## Requirements
- R1: While reset is held, `mem_vld` and `mem_rw` are 0. After reset every register and the program counter are 0, and the first bus access is a read at address 0000h.
- R2: Each instruction is fetched by a read at the program counter, and the program counter then advances by one.
- R3: The opcode sits in bits 15:11. Field A is bits 5:3 and field B is bits 2:0; each selects one of eight registers.
- R4: Opcode 00001 loads register B from the memory word addressed by register A. For example, 080Bh loads R3 from the word at address R1.
- R5: Opcode 00010 writes register A to the memory word addressed by register B, with `mem_rw`=1. For example, 101Ah writes R3 to the word at address R2.
- R6: Opcode 00100 is two words long and loads register B with the second word. For example, 2001h 0010h sets R1 to 0010h.
- R7: Opcode 00101 is two words long and jumps to the address held in the second word.
- R8: Opcode 00110 is two words long. It jumps to the second word when register A is greater than register B as an unsigned 16-bit number. Otherwise, including when the two are equal, execution goes on after the second word.
- R9: Opcode 00111 adds one to register B, wrapping from FFFFh to 0000h.
- R10: Opcode 00000 and every undefined opcode change no register and return to fetch.
- R11: `mem_rw` is 1 only while `mem_vld` is 1, and every access lasts exactly one cycle.
- R12: The copy program moves the 32 words at 0010h–002Fh to 0030h–004Fh, and R1 is 0030h when the loop exits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address of the current access |
| mem_rdata | input | 16 | Read data, sampled at the end of a read cycle |
| mem_wdata | output | 16 | Write data, valid during a write cycle |
| mem_vld | output | 1 | Access valid in this cycle |
| mem_rw | output | 1 | 1 for a write, 0 for a read |

## Verification
The hardest cases to reach from the ports are the boundaries of the greater-than branch. One is an operand pair whose order depends on signedness (8000h against 0001h). The other is equal operands, which must not branch. A wrong decision here only shows up as a changed instruction path, never directly on the bus. The stimulus program sends every wrong branch outcome into a self-jump trap, so the trap surfaces as missing memory writes. The copy loop also reaches its own edge: on the last pass it copies one word beyond the block, and the expected write sequence includes that extra write at 0050h. After the loop, a small tail program stores R1, which brings the register's value out through a memory write.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam logic [4:0] OPC_NOP   = 5'b00000;
  localparam logic [4:0] OPC_LOAD  = 5'b00001;
  localparam logic [4:0] OPC_STORE = 5'b00010;
  localparam logic [4:0] OPC_LOADI = 5'b00100;
  localparam logic [4:0] OPC_JMP   = 5'b00101;
  localparam logic [4:0] OPC_JGT   = 5'b00110;
  localparam logic [4:0] OPC_INC   = 5'b00111;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FREAD, ST_DECODE,
    ST_LDADDR, ST_LDREAD,
    ST_STADDR, ST_STWRITE,
    ST_IMADDR, ST_IMREAD,
    ST_INCR
  } cpu_state_e;

  typedef enum logic [0:0] {ALU_PASS, ALU_INC} alu_op_e;
  typedef enum logic [1:0] {PC_HOLD, PC_ALU, PC_MEM} pc_src_e;
  typedef enum logic [1:0] {AD_HOLD, AD_PC, AD_REGA, AD_REGB} ad_src_e;

  typedef struct packed {
    pc_src_e pc_src;
    logic    ir_we;
    ad_src_e ad_src;
    logic    rf_we;
    logic    rf_from_mem;
    logic    alu_a_pc;
    alu_op_e alu_op;
    logic    vld;
    logic    rw;
  } ctrl_t;

endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    case (op)
      ALU_INC: y = a + ONE;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] opcode,
  input  logic       a_gt_b,
  output cpu_state_e state,
  output ctrl_t      ctl
);
  cpu_state_e nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      ST_FADDR: begin
        ctl.ad_src = AD_PC;
        nxt = ST_FREAD;
      end
      ST_FREAD: begin
        ctl.vld      = 1'b1;
        ctl.ir_we    = 1'b1;
        ctl.alu_a_pc = 1'b1;
        ctl.alu_op   = ALU_INC;
        ctl.pc_src   = PC_ALU;
        nxt = ST_DECODE;
      end
      ST_DECODE: begin
        case (opcode)
          OPC_LOAD:                    nxt = ST_LDADDR;
          OPC_STORE:                   nxt = ST_STADDR;
          OPC_LOADI, OPC_JMP, OPC_JGT: nxt = ST_IMADDR;
          OPC_INC:                     nxt = ST_INCR;
          default:                     nxt = ST_FADDR;
        endcase
      end
      ST_LDADDR: begin
        ctl.ad_src = AD_REGA;
        nxt = ST_LDREAD;
      end
      ST_LDREAD: begin
        ctl.vld         = 1'b1;
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mem = 1'b1;
        nxt = ST_FADDR;
      end
      ST_STADDR: begin
        ctl.ad_src = AD_REGB;
        nxt = ST_STWRITE;
      end
      ST_STWRITE: begin
        ctl.vld = 1'b1;
        ctl.rw  = 1'b1;
        nxt = ST_FADDR;
      end
      ST_IMADDR: begin
        ctl.ad_src = AD_PC;
        nxt = ST_IMREAD;
      end
      ST_IMREAD: begin
        ctl.vld      = 1'b1;
        ctl.alu_a_pc = 1'b1;
        ctl.alu_op   = ALU_INC;
        ctl.pc_src   = PC_ALU;
        if (opcode == OPC_LOADI) begin
          ctl.rf_we       = 1'b1;
          ctl.rf_from_mem = 1'b1;
        end
        if (opcode == OPC_JMP || (opcode == OPC_JGT && a_gt_b))
          ctl.pc_src = PC_MEM;
        nxt = ST_FADDR;
      end
      ST_INCR: begin
        ctl.rf_we  = 1'b1;
        ctl.alu_op = ALU_INC;
        nxt = ST_FADDR;
      end
      default: nxt = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= nxt;
  end
endmodule

// File: rtl/cpu16_blkcopy.sv
module cpu16_blkcopy
  import cpu16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_vld,
  output logic          mem_rw
);
  localparam int RAW = $clog2(NREG);
  localparam int OPW = 5;

  logic            rst_meta, rst_sync_n;
  logic [DW-1:0]   pc_q, addr_q, alu_a, alu_y, rd_a, rd_b, rf_wdata;
  logic [OPW-1:0]  opcode;
  logic [RAW-1:0]  fld_a, fld_b;
  logic            a_gt_b;
  cpu_state_e      cur_state;
  ctrl_t           ctl;

  // reset: asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cpu16_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .opcode (opcode),
    .a_gt_b (a_gt_b),
    .state  (cur_state),
    .ctl    (ctl)
  );

  cpu16_regfile #(.W(DW), .N(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (ctl.rf_we),
    .waddr   (fld_b),
    .wdata   (rf_wdata),
    .raddr_a (fld_a),
    .rdata_a (rd_a),
    .raddr_b (fld_b),
    .rdata_b (rd_b)
  );

  assign alu_a = ctl.alu_a_pc ? pc_q : rd_b;

  cpu16_alu #(.W(DW)) u_alu (
    .a  (alu_a),
    .op (ctl.alu_op),
    .y  (alu_y)
  );

  assign a_gt_b   = rd_a > rd_b;
  assign rf_wdata = ctl.rf_from_mem ? mem_rdata : alu_y;

  // only the opcode and the two register fields are kept from the fetched word
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opcode <= '0;
      fld_a  <= '0;
      fld_b  <= '0;
    end else if (ctl.ir_we) begin
      opcode <= mem_rdata[DW-1 -: OPW];
      fld_a  <= mem_rdata[2*RAW-1 -: RAW];
      fld_b  <= mem_rdata[RAW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)              pc_q <= '0;
    else if (ctl.pc_src == PC_ALU) pc_q <= alu_y;
    else if (ctl.pc_src == PC_MEM) pc_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) addr_q <= '0;
    else begin
      case (ctl.ad_src)
        AD_PC:   addr_q <= pc_q;
        AD_REGA: addr_q <= rd_a;
        AD_REGB: addr_q <= rd_b;
        default: addr_q <= addr_q;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = rd_a;
  assign mem_vld   = ctl.vld;
  assign mem_rw    = ctl.rw;
endmodule

// File: rtl/cpu16_blkcopy_chk.sv
module cpu16_blkcopy_chk
  import cpu16_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_vld,
  input logic          mem_rw,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] pc,
  input cpu_state_e    state,
  input logic [4:0]    opcode
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic known_op;
  assign known_op = opcode inside {OPC_LOAD, OPC_STORE, OPC_LOADI, OPC_JMP, OPC_JGT, OPC_INC};

  AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rw |-> mem_vld);                                                  // R11
  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld |=> !mem_vld);                                                // R11
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FADDR) |=> (mem_addr == $past(pc)));                     // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREAD) |=> (pc == $past(pc) + ONE));                     // R2
  AST_UNDEF_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && !known_op) |=> (state == ST_FADDR));           // R10
  AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREAD) |-> (mem_vld && !mem_rw));                        // R2
endmodule

bind cpu16_blkcopy cpu16_blkcopy_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mem_vld  (mem_vld),
  .mem_rw   (mem_rw),
  .mem_addr (mem_addr),
  .pc       (pc_q),
  .state    (cur_state),
  .opcode   (opcode)
);

// File: tb/cpu16_blkcopy_bench.sv
module cpu16_blkcopy_bench;

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } wr_item_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_vld, mem_rw;

  logic [15:0] mem [256];
  wr_item_t    expq [$];
  int          n_vec  = 0;
  int          n_miss = 0;
  bit          first_pend = 0;

  cpu16_blkcopy u_cpu16_blkcopy (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_vld   (mem_vld),
    .mem_rw    (mem_rw)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk)
    if (mem_vld && mem_rw) mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [15:0] pat(input int i);
    return (16'h1000 * 16'(i % 16)) ^ (16'(i) * 16'h0029) ^ 16'h3C5A;
  endfunction

  // monitor: compares every write against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rw && !mem_vld) begin
        n_miss++;
        $display("FAIL R11: mem_rw=%0b with mem_vld=%0b, expected mem_vld=1", mem_rw, mem_vld);
      end
      if (mem_vld && first_pend) begin
        n_vec++;
        first_pend = 0;
        if (mem_addr != 16'h0000 || mem_rw) begin
          n_miss++;
          $display("FAIL R1: first access addr=%h rw=%0b, expected addr=0000 rw=0", mem_addr, mem_rw);
        end
      end
      if (mem_vld && mem_rw) begin
        n_vec++;
        if (expq.size() == 0) begin
          n_miss++;
          $display("FAIL R5: unexpected write addr=%h data=%h, expected no write", mem_addr, mem_wdata);
        end else begin
          wr_item_t e;
          e = expq.pop_front();
          if (mem_addr !== e.addr || mem_wdata !== e.data) begin
            n_miss++;
            $display("FAIL %s: write addr=%h data=%h, expected addr=%h data=%h",
                     e.tag, mem_addr, mem_wdata, e.addr, e.data);
          end
        end
      end
    end
  end

  task automatic push(input logic [15:0] a, input logic [15:0] d, input string t);
    wr_item_t e;
    e.addr = a; e.data = d; e.tag = t;
    expq.push_back(e);
  endtask

  task automatic run_phase(input string name);
    int guard = 0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (mem_vld !== 1'b0 || mem_rw !== 1'b0) begin
      n_miss++;
      $display("FAIL R1: in reset vld=%0b rw=%0b, expected 0 0", mem_vld, mem_rw);
    end
    first_pend = 1;
    rst_n = 1'b1;
    while (expq.size() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (expq.size() != 0) begin
      n_miss++;
      $display("FAIL watchdog (%s): %0d writes missing, expected 0", name, expq.size());
      expq.delete();
    end
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  initial begin
    rst_n = 1'b0;

    // Phase A: opcode corner cases (R3..R10)
    clear_mem();
    mem[8'h00] = 16'h0000;  // no-op (R10)
    mem[8'h01] = 16'hF800;  // undefined opcode (R10)
    mem[8'h02] = 16'h2001; mem[8'h03] = 16'h8000;  // R1=8000
    mem[8'h04] = 16'h2002; mem[8'h05] = 16'h0001;  // R2=0001
    mem[8'h06] = 16'h300A; mem[8'h07] = 16'h000A;  // R1>R2 unsigned: taken
    mem[8'h08] = 16'h2800; mem[8'h09] = 16'h0008;  // trap
    mem[8'h0A] = 16'h3011; mem[8'h0B] = 16'h000E;  // R2>R1: not taken
    mem[8'h0C] = 16'h2800; mem[8'h0D] = 16'h0010;  // jump over trap (R7)
    mem[8'h0E] = 16'h2800; mem[8'h0F] = 16'h000E;  // trap
    mem[8'h10] = 16'h3802;                         // R2=0002
    mem[8'h11] = 16'h2003; mem[8'h12] = 16'h0002;  // R3=0002
    mem[8'h13] = 16'h3013; mem[8'h14] = 16'h000E;  // equal: not taken
    mem[8'h15] = 16'h2004; mem[8'h16] = 16'h0040;  // R4=0040
    mem[8'h17] = 16'h1014;                         // [R4]<=R2
    mem[8'h18] = 16'h2005; mem[8'h19] = 16'hFFFF;  // R5=FFFF
    mem[8'h1A] = 16'h3805;                         // R5 wraps
    mem[8'h1B] = 16'h102C;                         // [R4]<=R5
    mem[8'h1C] = 16'h2007; mem[8'h1D] = 16'h0042;  // R7=0042
    mem[8'h1E] = 16'h083E;                         // R6<=[R7]
    mem[8'h1F] = 16'h1034;                         // [R4]<=R6
    mem[8'h20] = 16'h1004;                         // [R4]<=R0
    mem[8'h21] = 16'h2800; mem[8'h22] = 16'h0021;  // halt
    mem[8'h42] = 16'hABCD;
    push(16'h0040, 16'h0002, "R8,R7,R10,R5");
    push(16'h0040, 16'h0000, "R9");
    push(16'h0040, 16'hABCD, "R4,R6,R3");
    push(16'h0040, 16'h0000, "R1");
    run_phase("phase A");

    // Phase B: block copy program (R12, R2)
    clear_mem();
    mem[8'h00] = 16'h2001; mem[8'h01] = 16'h0010;
    mem[8'h02] = 16'h2002; mem[8'h03] = 16'h0030;
    mem[8'h04] = 16'h2006; mem[8'h05] = 16'h002F;
    mem[8'h06] = 16'h080B;
    mem[8'h07] = 16'h101A;
    mem[8'h08] = 16'h300E; mem[8'h09] = 16'h0060;
    mem[8'h0A] = 16'h3801;
    mem[8'h0B] = 16'h3802;
    mem[8'h0C] = 16'h2800; mem[8'h0D] = 16'h0006;
    mem[8'h60] = 16'h2004; mem[8'h61] = 16'h0070;  // R4=0070
    mem[8'h62] = 16'h100C;                         // [R4]<=R1
    mem[8'h63] = 16'h2800; mem[8'h64] = 16'h0063;
    for (int i = 0; i < 32; i++) mem[8'h10 + i] = pat(i);
    for (int i = 0; i < 32; i++) push(16'h0030 + 16'(i), pat(i), "R12,R2");
    push(16'h0050, pat(0), "R12");   // last pass copies one word past the block
    push(16'h0070, 16'h0030, "R12"); // R1 at loop exit
    run_phase("phase B");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule